// File: doc/BRIEF.md
# Recorder Command Interpreter

This block sits between a host control link and the transport logic of a tape-style recorder. It takes a byte stream of ASCII messages, collects each message up to its line terminator, decodes it and executes it in one cycle. It then sends a short ASCII reply back out on a byte stream. Action messages change the transport mode, the selected bit rate, or request a tape load or unload. Query messages return a status string built from the current mode, the rate and the tape sensor inputs.

Both byte streams use valid/ready handshakes. A byte moves on a rising clock edge where valid and ready are both high. The input side accepts one message at a time. After a terminator ends a non-empty message, `in_ready` stays low until the last byte of that message's reply has been taken. The output side may be stalled for any number of cycles by holding `rsp_ready` low. While stalled, the pending byte stays on `rsp_data`. Transport mode, rate selection and the load/unload strobes are plain signals.

Top module: `recorder_cmd_engine`

## Requirements
- R1: An input byte is taken on a clock edge with `in_valid` and `in_ready` both high. CR (0x0D) or LF (0x0A) ends a message. A terminator that arrives with no characters collected is dropped and produces no reply. `in_ready` is low from the terminator of a non-empty message until its last reply byte is taken.
- R2: A reply byte is taken on a clock edge with `rsp_valid` and `rsp_ready` both high. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold. Every reply ends with LF (0x0A). An accepted action replies `OK` and a rejected message replies `ER`.
- R3: The mode commands are `REC`, `PLAY`, `SYNR`, `SYNP`, `FF` and `RW`. They set `xport_mode` to 1, 2, 3, 4, 5 and 6 respectively; 0 means stopped. Each is accepted only while `tape_mounted` and `tape_ready` are both high. A rejected mode command leaves the mode unchanged.
- R4: `STOP` is always accepted and sets `xport_mode` to 0.
- R5: `LOAD` is accepted only while the mode is 0, and it raises `load_pulse` for exactly one cycle. `UNLD` is always accepted, sets the mode to 0 and raises `unload_pulse` for one cycle.
- R6: `BR=` followed by one of `0064`, `0128`, `0256`, `0512`, `1024`, `2048` sets `rate_sel` to 0, 1, 2, 3, 4 or 5 respectively. Any other argument is rejected and leaves `rate_sel` unchanged.
- R7: Mode 5 returns to 0 on its own while `at_eot` is high. Mode 6 returns to 0 on its own while `at_bot` is high.
- R8: An unknown message is rejected with `ER`, and so is a message of more than 8 characters. The extra characters are discarded up to the terminator.
- R9: `?XPT` replies with the mode name: `STOP`, `REC`, `PLAY`, `SYNR`, `SYNP`, `FF` or `RW`.
- R10: `?BR` replies `BR=` followed by the four digits of the selected rate.
- R11: `?TAPE` replies `NOTAPE` when not mounted, `NRDY` when mounted but not ready, and `RDY` otherwise. `?POS` replies `BOT` if `at_bot` is high, else `EOT` if `at_eot` is high, else `MID`.
- R12: `?REM` replies `BEST=` followed by two decimal digits of `remain_pct`, with values above 99 reported as 99. `?DATA` replies `DATA` when `data_avail` is high and `NODATA` otherwise.
- R13: After reset, `in_ready` is 1, `rsp_valid` is 0, `xport_mode` is 0, `rate_sel` is 0 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Incoming message byte |
| in_valid | input | 1 | Incoming byte present |
| in_ready | output | 1 | Interpreter can take a byte |
| rsp_data | output | 8 | Reply byte |
| rsp_valid | output | 1 | Reply byte present |
| rsp_ready | input | 1 | Downstream takes the reply byte |
| tape_mounted | input | 1 | Tape is in the transport |
| tape_ready | input | 1 | Mounted tape is ready to move |
| at_bot | input | 1 | Tape at its beginning |
| at_eot | input | 1 | Tape at its end |
| remain_pct | input | 7 | Remaining tape in percent |
| data_avail | input | 1 | Data is available |
| xport_mode | output | 3 | Transport mode code (R3) |
| rate_sel | output | 3 | Selected rate index (R6) |
| load_pulse | output | 1 | One-cycle load request |
| unload_pulse | output | 1 | One-cycle unload request |

## Verification
The assertions check the following on every cycle:
- a stalled reply byte holds;
- the final reply byte is LF;
- input is blocked while a reply is pending;
- the rate index stays in range;
- the automatic stops at either tape end take effect;
- a load strobe only follows a stopped transport;
- a mode command with no ready tape leaves the mode alone.

Only the bench's scenarios can show three things. The first is that each message text maps to the right reply string. The second is that query strings follow the sensors. The third is that overlong, malformed and empty lines are handled as required, under random back-pressure and random sensor changes.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam int CHAR_W    = 8;
  localparam int KEY_CHARS = 8;
  localparam int WORD_W    = CHAR_W * KEY_CHARS;
  localparam int RATE_N    = 6;
  localparam logic [7:0] ASC_CR = 8'h0D;
  localparam logic [7:0] ASC_LF = 8'h0A;

  typedef enum logic [2:0] {
    XM_STOP = 3'd0, XM_REC = 3'd1, XM_PLAY = 3'd2, XM_SYNR = 3'd3,
    XM_SYNP = 3'd4, XM_FF = 3'd5, XM_RW = 3'd6
  } xmode_e;

  typedef enum logic [4:0] {
    OP_BAD, OP_REC, OP_PLAY, OP_SYNR, OP_SYNP, OP_STOP, OP_FF, OP_RW,
    OP_LOAD, OP_UNLD, OP_RATE, OP_QXPT, OP_QRATE, OP_QTAPE, OP_QPOS,
    OP_QREM, OP_QDATA
  } op_e;

  function automatic logic is_motion(input op_e op);
    return (op == OP_REC) || (op == OP_PLAY) || (op == OP_SYNR) ||
           (op == OP_SYNP) || (op == OP_FF) || (op == OP_RW);
  endfunction

  function automatic xmode_e motion_mode(input op_e op);
    case (op)
      OP_REC:  return XM_REC;
      OP_PLAY: return XM_PLAY;
      OP_SYNR: return XM_SYNR;
      OP_SYNP: return XM_SYNP;
      OP_FF:   return XM_FF;
      OP_RW:   return XM_RW;
      default: return XM_STOP;
    endcase
  endfunction

  function automatic logic [31:0] rate_digits(input logic [2:0] idx);
    case (idx)
      3'd0:    return "0064";
      3'd1:    return "0128";
      3'd2:    return "0256";
      3'd3:    return "0512";
      3'd4:    return "1024";
      3'd5:    return "2048";
      default: return "0000";
    endcase
  endfunction
endpackage

// File: rtl/rce_linebuf.sv
module rce_linebuf import rce_pkg::*; #(
  parameter int BUF_LEN = 8,
  localparam int CNT_W = $clog2(BUF_LEN + 1),
  localparam int IDX_W = $clog2(BUF_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              done,
  output logic              exec,
  output logic              ovf,
  output logic [CNT_W-1:0]  len,
  output logic [WORD_W-1:0] word
);
  typedef enum logic [1:0] {LB_COL, LB_EXE, LB_WAIT} lb_e;
  lb_e              st;
  logic [7:0]       mem [BUF_LEN];
  logic [CNT_W-1:0] cnt;
  logic             ovf_q;
  logic             take, is_term;

  assign in_ready = (st == LB_COL);
  assign take     = in_valid && in_ready;
  assign is_term  = (in_data == ASC_CR) || (in_data == ASC_LF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= LB_COL;
      cnt   <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < BUF_LEN; i++) mem[i] <= '0;
    end else begin
      case (st)
        LB_COL: if (take) begin
          if (is_term) begin
            if (cnt != '0 || ovf_q) st <= LB_EXE;
          end else if (cnt == CNT_W'(BUF_LEN)) begin
            ovf_q <= 1'b1;
          end else begin
            mem[cnt[IDX_W-1:0]] <= in_data;
            cnt <= cnt + 1'b1;
          end
        end
        LB_EXE: st <= LB_WAIT;
        LB_WAIT: if (done) begin
          st    <= LB_COL;
          cnt   <= '0;
          ovf_q <= 1'b0;
        end
        default: st <= LB_COL;
      endcase
    end
  end

  assign exec = (st == LB_EXE);
  assign ovf  = ovf_q;
  assign len  = cnt;

  for (genvar g = 0; g < KEY_CHARS; g++) begin : g_word
    if (g < BUF_LEN) begin : g_live
      assign word[WORD_W-1-8*g -: 8] = (CNT_W'(g) < cnt) ? mem[g] : 8'h00;
    end else begin : g_pad
      assign word[WORD_W-1-8*g -: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/rce_decode.sv
module rce_decode import rce_pkg::*; #(
  parameter int LEN_W = 4
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  len,
  input  logic              ovf,
  output op_e               op,
  output logic [2:0]        rate_idx
);
  function automatic logic same(input logic [WORD_W-1:0] w, input logic [LEN_W-1:0] l,
                                input logic [WORD_W-1:0] key, input int kl);
    return (w == key) && (int'(l) == kl);
  endfunction

  always_comb begin
    op       = OP_BAD;
    rate_idx = '0;
    if (ovf)                                         op = OP_BAD;
    else if (same(word, len, {"REC",   40'd0}, 3))   op = OP_REC;
    else if (same(word, len, {"PLAY",  32'd0}, 4))   op = OP_PLAY;
    else if (same(word, len, {"SYNR",  32'd0}, 4))   op = OP_SYNR;
    else if (same(word, len, {"SYNP",  32'd0}, 4))   op = OP_SYNP;
    else if (same(word, len, {"STOP",  32'd0}, 4))   op = OP_STOP;
    else if (same(word, len, {"FF",    48'd0}, 2))   op = OP_FF;
    else if (same(word, len, {"RW",    48'd0}, 2))   op = OP_RW;
    else if (same(word, len, {"LOAD",  32'd0}, 4))   op = OP_LOAD;
    else if (same(word, len, {"UNLD",  32'd0}, 4))   op = OP_UNLD;
    else if (same(word, len, {"?XPT",  32'd0}, 4))   op = OP_QXPT;
    else if (same(word, len, {"?BR",   40'd0}, 3))   op = OP_QRATE;
    else if (same(word, len, {"?TAPE", 24'd0}, 5))   op = OP_QTAPE;
    else if (same(word, len, {"?POS",  32'd0}, 4))   op = OP_QPOS;
    else if (same(word, len, {"?REM",  32'd0}, 4))   op = OP_QREM;
    else if (same(word, len, {"?DATA", 24'd0}, 5))   op = OP_QDATA;
    else if (word[WORD_W-1 -: 24] == "BR=" && int'(len) == 7) begin
      for (int k = 0; k < RATE_N; k++) begin
        if (word[WORD_W-25 -: 32] == rate_digits(3'(k))) begin
          op       = OP_RATE;
          rate_idx = 3'(k);
        end
      end
    end
  end
endmodule

// File: rtl/rce_xport.sv
module rce_xport import rce_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  op_e        op,
  input  logic [2:0] rate_new,
  input  logic       tape_ok,
  input  logic       at_bot,
  input  logic       at_eot,
  output xmode_e     mode,
  output logic [2:0] rate_sel,
  output logic       accept,
  output logic       load_p,
  output logic       unload_p
);
  always_comb begin
    case (op)
      OP_REC, OP_PLAY, OP_SYNR, OP_SYNP, OP_FF, OP_RW: accept = tape_ok;
      OP_LOAD: accept = (mode == XM_STOP);
      OP_BAD:  accept = 1'b0;
      default: accept = 1'b1;
    endcase
  end

  logic go;
  assign go = exec && accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= XM_STOP;
      rate_sel <= '0;
      load_p   <= 1'b0;
      unload_p <= 1'b0;
    end else begin
      load_p   <= go && (op == OP_LOAD);
      unload_p <= go && (op == OP_UNLD);
      if (go && is_motion(op))                          mode <= motion_mode(op);
      else if (go && (op == OP_STOP || op == OP_UNLD))  mode <= XM_STOP;
      else if ((mode == XM_FF && at_eot) || (mode == XM_RW && at_bot)) mode <= XM_STOP;
      if (go && op == OP_RATE) rate_sel <= rate_new;
    end
  end

  p_ff_autostop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XM_FF && at_eot && !exec) |=> (mode == XM_STOP));
  p_rw_autostop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == XM_RW && at_bot && !exec) |=> (mode == XM_STOP));
  p_no_move_unready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && is_motion(op) && !tape_ok && mode != XM_FF && mode != XM_RW) |=> $stable(mode));
  p_load_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |-> ($past(mode) == XM_STOP));
  p_rate_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rate_sel < 3'(RATE_N));
endmodule

// File: rtl/rce_reply.sv
module rce_reply import rce_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  op_e        op,
  input  logic       accept,
  input  xmode_e     mode,
  input  logic [2:0] rate_sel,
  input  logic       tape_mounted,
  input  logic       tape_ready,
  input  logic       at_bot,
  input  logic       at_eot,
  input  logic [6:0] remain_pct,
  input  logic       data_avail,
  output logic [7:0] rsp_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic       done
);
  localparam int LEN_W = $clog2(KEY_CHARS + 1);
  localparam int IDX_W = $clog2(KEY_CHARS);

  logic [WORD_W-1:0] txt, rbuf;
  logic [LEN_W-1:0]  tlen, rlen;
  logic [IDX_W-1:0]  ridx;
  logic              busy, last;
  logic [6:0]        pct;

  assign pct = (remain_pct > 7'd99) ? 7'd99 : remain_pct;

  always_comb begin
    txt  = {"ER", ASC_LF, 40'd0};
    tlen = LEN_W'(3);
    if (accept) begin
      case (op)
        OP_QXPT: begin
          case (mode)
            XM_REC:  begin txt = {"REC",  ASC_LF, 32'd0}; tlen = LEN_W'(4); end
            XM_PLAY: begin txt = {"PLAY", ASC_LF, 24'd0}; tlen = LEN_W'(5); end
            XM_SYNR: begin txt = {"SYNR", ASC_LF, 24'd0}; tlen = LEN_W'(5); end
            XM_SYNP: begin txt = {"SYNP", ASC_LF, 24'd0}; tlen = LEN_W'(5); end
            XM_FF:   begin txt = {"FF",   ASC_LF, 40'd0}; tlen = LEN_W'(3); end
            XM_RW:   begin txt = {"RW",   ASC_LF, 40'd0}; tlen = LEN_W'(3); end
            default: begin txt = {"STOP", ASC_LF, 24'd0}; tlen = LEN_W'(5); end
          endcase
        end
        OP_QRATE: begin
          txt = {"BR=", rate_digits(rate_sel), ASC_LF}; tlen = LEN_W'(8);
        end
        OP_QTAPE: begin
          if (!tape_mounted)   begin txt = {"NOTAPE", ASC_LF, 8'd0};  tlen = LEN_W'(7); end
          else if (tape_ready) begin txt = {"RDY",    ASC_LF, 32'd0}; tlen = LEN_W'(4); end
          else                 begin txt = {"NRDY",   ASC_LF, 24'd0}; tlen = LEN_W'(5); end
        end
        OP_QPOS: begin
          if (at_bot)      begin txt = {"BOT", ASC_LF, 32'd0}; tlen = LEN_W'(4); end
          else if (at_eot) begin txt = {"EOT", ASC_LF, 32'd0}; tlen = LEN_W'(4); end
          else             begin txt = {"MID", ASC_LF, 32'd0}; tlen = LEN_W'(4); end
        end
        OP_QREM: begin
          txt  = {"BEST=", 8'h30 + 8'(pct / 7'd10), 8'h30 + 8'(pct % 7'd10), ASC_LF};
          tlen = LEN_W'(8);
        end
        OP_QDATA: begin
          if (data_avail) begin txt = {"DATA",   ASC_LF, 24'd0}; tlen = LEN_W'(5); end
          else            begin txt = {"NODATA", ASC_LF, 8'd0};  tlen = LEN_W'(7); end
        end
        default: begin txt = {"OK", ASC_LF, 40'd0}; tlen = LEN_W'(3); end
      endcase
    end
  end

  assign rsp_valid = busy;
  assign rsp_data  = rbuf[8*(KEY_CHARS-1-int'(ridx)) +: 8];
  assign last      = ({1'b0, ridx} == rlen - 1'b1);
  assign done      = busy && rsp_ready && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf <= '0;
      rlen <= '0;
      ridx <= '0;
      busy <= 1'b0;
    end else if (exec) begin
      rbuf <= txt;
      rlen <= tlen;
      ridx <= '0;
      busy <= 1'b1;
    end else if (busy && rsp_ready) begin
      if (last) busy <= 1'b0;
      else      ridx <= ridx + 1'b1;
    end
  end

  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_ready) |=> (busy && $stable(rsp_data)));
  p_rsp_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |-> (rsp_data == ASC_LF));
endmodule

// File: rtl/recorder_cmd_engine.sv
module recorder_cmd_engine import rce_pkg::*; #(
  parameter int BUF_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] rsp_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  input  logic       tape_mounted,
  input  logic       tape_ready,
  input  logic       at_bot,
  input  logic       at_eot,
  input  logic [6:0] remain_pct,
  input  logic       data_avail,
  output logic [2:0] xport_mode,
  output logic [2:0] rate_sel,
  output logic       load_pulse,
  output logic       unload_pulse
);
  localparam int CNT_W = $clog2(BUF_LEN + 1);

  logic              exec, ovf, done, accept;
  logic [CNT_W-1:0]  len;
  logic [WORD_W-1:0] word;
  op_e               op;
  logic [2:0]        rate_new;
  xmode_e            mode;

  rce_linebuf #(.BUF_LEN(BUF_LEN)) u_linebuf (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .done(done), .exec(exec), .ovf(ovf), .len(len), .word(word)
  );

  rce_decode #(.LEN_W(CNT_W)) u_decode (
    .word(word), .len(len), .ovf(ovf), .op(op), .rate_idx(rate_new)
  );

  rce_xport u_xport (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .rate_new(rate_new),
    .tape_ok(tape_mounted && tape_ready), .at_bot(at_bot), .at_eot(at_eot),
    .mode(mode), .rate_sel(rate_sel), .accept(accept),
    .load_p(load_pulse), .unload_p(unload_pulse)
  );

  rce_reply u_reply (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .accept(accept), .mode(mode),
    .rate_sel(rate_sel), .tape_mounted(tape_mounted), .tape_ready(tape_ready),
    .at_bot(at_bot), .at_eot(at_eot), .remain_pct(remain_pct), .data_avail(data_avail),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .done(done)
  );

  assign xport_mode = mode;

  p_in_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !in_ready);
endmodule

// File: tb/recorder_cmd_engine_bench.sv
module recorder_cmd_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] rsp_data;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic       tape_mounted = 1'b0, tape_ready = 1'b0, at_bot = 1'b0, at_eot = 1'b0;
  logic [6:0] remain_pct = '0;
  logic       data_avail = 1'b0;
  logic [2:0] xport_mode, rate_sel;
  logic       load_pulse, unload_pulse;

  always #4 clk = ~clk;

  recorder_cmd_engine u_recorder_cmd_engine (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .tape_mounted(tape_mounted), .tape_ready(tape_ready), .at_bot(at_bot), .at_eot(at_eot),
    .remain_pct(remain_pct), .data_avail(data_avail), .xport_mode(xport_mode),
    .rate_sel(rate_sel), .load_pulse(load_pulse), .unload_pulse(unload_pulse)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] rx [32];
  int  rx_n = 0;
  bit  rx_line = 0;
  bit  rdy_rand = 0;
  int  load_cnt = 0, unload_cnt = 0;
  int  m_mode = 0, m_rate = 0, m_loads = 0, m_unloads = 0;
  string rates [6] = '{"0064", "0128", "0256", "0512", "1024", "2048"};
  string names [7] = '{"STOP", "REC", "PLAY", "SYNR", "SYNP", "FF", "RW"};

  always @(negedge clk) begin
    logic r;
    r = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
    rsp_ready = r;
    if (rsp_valid && r) begin
      if (rx_n < 32) rx[rx_n] = rsp_data;
      rx_n++;
      if (rsp_data == 8'h0A) rx_line = 1;
    end
  end

  always @(negedge clk) begin
    if (load_pulse) load_cnt++;
    if (unload_pulse) unload_cnt++;
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  function automatic string vis(input string s);
    string o = "";
    for (int i = 0; i < s.len(); i++) o = (s[i] == 8'h0A) ? {o, "~"} : $sformatf("%s%c", o, s[i]);
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %s expected %s", req, vis(act), vis(exp));
    end
  endtask

  function automatic int motion_code(input string s);
    for (int k = 1; k < 7; k++) if (s == names[k]) return k;
    return -1;
  endfunction

  task automatic autostop();
    if (m_mode == 5 && at_eot) m_mode = 0;
    if (m_mode == 6 && at_bot) m_mode = 0;
  endtask

  task automatic model(input string msg, output string exp);
    bit ok = tape_mounted && tape_ready;
    int mc = motion_code(msg);
    int p;
    autostop();
    exp = "ER\n";
    if (msg.len() > 8) return;
    if (mc > 0) begin
      if (ok) begin m_mode = mc; exp = "OK\n"; end
    end else if (msg == "STOP") begin m_mode = 0; exp = "OK\n"; end
    else if (msg == "LOAD") begin
      if (m_mode == 0) begin m_loads++; exp = "OK\n"; end
    end else if (msg == "UNLD") begin m_mode = 0; m_unloads++; exp = "OK\n"; end
    else if (msg.len() == 7 && msg.substr(0, 2) == "BR=") begin
      for (int k = 0; k < 6; k++)
        if (msg.substr(3, 6) == rates[k]) begin m_rate = k; exp = "OK\n"; end
    end
    else if (msg == "?XPT") exp = {names[m_mode], "\n"};
    else if (msg == "?BR") exp = {"BR=", rates[m_rate], "\n"};
    else if (msg == "?TAPE") exp = !tape_mounted ? "NOTAPE\n" : (tape_ready ? "RDY\n" : "NRDY\n");
    else if (msg == "?POS") exp = at_bot ? "BOT\n" : (at_eot ? "EOT\n" : "MID\n");
    else if (msg == "?REM") begin
      p = (remain_pct > 99) ? 99 : int'(remain_pct);
      exp = $sformatf("BEST=%02d\n", p);
    end
    else if (msg == "?DATA") exp = data_avail ? "DATA\n" : "NODATA\n";
    autostop();
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_sensors(input bit m, input bit r, input bit b, input bit e,
                             input logic [6:0] pc, input bit d);
    @(negedge clk);
    tape_mounted = m; tape_ready = r; at_bot = b; at_eot = e; remain_pct = pc; data_avail = d;
    autostop();
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input string msg, input logic [7:0] term, input string req);
    string exp, got;
    model(msg, exp);
    rx_n = 0; rx_line = 0;
    for (int i = 0; i < msg.len(); i++) put_byte(msg[i]);
    put_byte(term);
    while (!rx_line) @(negedge clk);
    @(negedge clk);
    got = "";
    for (int i = 0; i < rx_n && i < 32; i++) got = $sformatf("%s%c", got, rx[i]);
    chk(got == exp, {req, " reply to ", msg}, got, exp);
    chk(int'(xport_mode) == m_mode, {req, " mode after ", msg},
        $sformatf("%0d", xport_mode), $sformatf("%0d", m_mode));
    chk(int'(rate_sel) == m_rate, {req, " rate after ", msg},
        $sformatf("%0d", rate_sel), $sformatf("%0d", m_rate));
    chk(load_cnt == m_loads && unload_cnt == m_unloads, {req, " strobes after ", msg},
        $sformatf("%0d/%0d", load_cnt, unload_cnt), $sformatf("%0d/%0d", m_loads, m_unloads));
  endtask

  string pool [24] = '{"REC", "PLAY", "SYNR", "SYNP", "STOP", "FF", "RW", "LOAD", "UNLD",
                       "BR=0512", "BR=2048", "BR=0064", "BR=0100", "?XPT", "?BR", "?TAPE",
                       "?POS", "?REM", "?DATA", "XYZ", "BR=064", "RECORDINGS", "rec", "?FOO"};

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(in_ready == 1'b1 && rsp_valid == 1'b0, "R13 handshake", $sformatf("%b%b", in_ready, rsp_valid), "10");
    chk(xport_mode == 3'd0 && rate_sel == 3'd0 && !load_pulse && !unload_pulse, "R13 outputs",
        $sformatf("%0d %0d", xport_mode, rate_sel), "0 0");

    // R1 empty line is dropped
    rx_n = 0;
    put_byte(8'h0A);
    put_byte(8'h0D);
    repeat (10) @(negedge clk);
    chk(rx_n == 0 && in_ready == 1'b1 && rsp_valid == 1'b0, "R1 empty line",
        $sformatf("%0d bytes", rx_n), "0 bytes");

    set_sensors(0, 0, 1, 0, 7'd50, 0);
    send("REC", 8'h0D, "R3 unmounted");
    send("?TAPE", 8'h0A, "R11 notape");
    set_sensors(1, 0, 1, 0, 7'd50, 0);
    send("?TAPE", 8'h0D, "R11 not ready");
    send("PLAY", 8'h0A, "R3 not ready");
    set_sensors(1, 1, 1, 0, 7'd50, 1);
    send("?TAPE", 8'h0A, "R11 ready");
    send("SYNR", 8'h0A, "R3 accepted");
    send("?XPT", 8'h0A, "R9 name");
    send("LOAD", 8'h0A, "R5 load while moving");
    send("STOP", 8'h0D, "R4 stop");
    send("LOAD", 8'h0A, "R5 load stopped");
    send("SYNP", 8'h0A, "R3 sync play");
    send("UNLD", 8'h0A, "R5 unload");
    send("FF", 8'h0A, "R3 wind");
    set_sensors(1, 1, 0, 1, 7'd50, 1);
    chk(xport_mode == 3'd0, "R7 end stop", $sformatf("%0d", xport_mode), "0");
    send("RW", 8'h0A, "R3 rewind");
    send("?XPT", 8'h0A, "R9 rewinding");
    set_sensors(1, 1, 1, 0, 7'd50, 1);
    chk(xport_mode == 3'd0, "R7 head stop", $sformatf("%0d", xport_mode), "0");
    send("BR=1024", 8'h0A, "R6 legal");
    send("?BR", 8'h0A, "R10 readback");
    send("BR=0100", 8'h0A, "R6 illegal");
    send("BR=064", 8'h0A, "R6 short");
    send("?BR", 8'h0D, "R10 unchanged");
    send("ABCDEFGHIJ", 8'h0A, "R8 overflow");
    send("ABCDEFGH", 8'h0A, "R8 eight chars");
    send("XYZ", 8'h0A, "R8 unknown");
    set_sensors(1, 1, 0, 0, 7'd100, 1);
    send("?REM", 8'h0A, "R12 clamp");
    send("?DATA", 8'h0A, "R12 data");
    send("?POS", 8'h0A, "R11 middle");
    set_sensors(1, 1, 0, 1, 7'd5, 0);
    send("?REM", 8'h0A, "R12 pad");
    send("?DATA", 8'h0A, "R12 nodata");
    send("?POS", 8'h0A, "R11 end");

    // R2 random traffic with back-pressure
    rdy_rand = 1;
    for (int n = 0; n < 220; n++) begin
      if (n % 4 == 0) begin
        int pos = $urandom_range(0, 5);
        set_sensors($urandom_range(0, 7) != 0, $urandom_range(0, 5) != 0, pos == 0, pos == 1,
                    7'($urandom_range(0, 127)), 1'($urandom_range(0, 1)));
      end
      if ($urandom_range(0, 5) == 0) put_byte(8'h0A);
      send(pool[$urandom_range(0, 23)], $urandom_range(0, 1) ? 8'h0A : 8'h0D, "R2 random");
    end
    summary();
  end
endmodule